// File: doc/BRIEF.md
# Masked interrupt status controller

This block collects interrupt events from the transmit and receive engines of a network controller into a bank of sticky status bits. It drives one level interrupt line toward the CPU. Each source has its own status bit. Any hardware event pulse sets its bit, and the bit stays set until software reads the status register. That read returns the current value and wipes every bit at once.

A mask register chooses which status bits may raise the line. A global enable register must be nonzero before a new assertion can start. Once the line is high, it stays high until no unmasked status bit remains, even if the global enable is dropped in the meantime. Software can raise an interrupt by writing a command bit, which sets the software status bit. Writes to the status register and events on bits with no source are rejected. Both are reported on a one-cycle error output.

Access uses a plain 32-bit word port with separate read and write strobes and a 2-bit word address:

| Address | Register |
|---------|----------|
| 0 | status |
| 1 | mask |
| 2 | global enable |
| 3 | command |

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the following all read zero: status, mask, global enable, the interrupt line and the error output.
- R2: An event pulse on a source bit sets that status bit at the next clock edge. Events OR into the bits already set.
- R3: A read of the status register (address 0) returns the value held before the read, and all status bits are zero after that clock edge.
- R4: An event arriving in the same cycle as a status read stays set after the read clears the register.
- R5: A write to the status register leaves it unchanged, and the error output is high in the following cycle.
- R6: Event bits 11 to 31 have no source. They never set status, and they raise the error output in the following cycle.
- R7: The line rises one cycle after the status register holds a bit that is also set in the mask, provided the global enable (address 2) is nonzero.
- R8: When the AND of status and mask becomes zero (through a read-clear or a mask write), the line falls one cycle later.
- R9: A mask write re-evaluates the line: unmasking a pending bit raises it two cycles after the write. Masking every pending bit lowers it two cycles after the write.
- R10: A zero global enable keeps the line from rising. Once the line is high, it stays high after the enable is cleared, until no unmasked status bit remains.
- R11: A write to the command register (address 3) with bit 0 set posts the software status bit 8. A command write with bit 0 clear posts nothing.
- R12: The status bit positions are:
  - 0: transmit OK
  - 1: transmit error
  - 2: transmit descriptor
  - 3: transmit idle
  - 4: receive OK
  - 5: receive error
  - 6: receive idle
  - 7: receive overrun
  - 8: software
  - 9: transmit reset complete
  - 10: receive reset complete

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| event_i | input | 32 | Event pulses, one bit per status source |
| irq_o | output | 1 | Registered level interrupt line |
| err_o | output | 1 | One-cycle flag for a rejected status write or a reserved event |

## Verification
The bench targets an event that lands in the same cycle as a status read. A design that cleared after merging would lose that event for good. It checks that a status write changes nothing, because a design that accepted the write would let software forge or drop interrupts. It also checks the pending latch. A design without the latch would drop the line when the enable is cleared. A design that ignored the enable would raise the line with the enable at zero. Mask writes are checked in both directions with exact cycle counts, so a line that failed to re-evaluate on a mask change, or that ran combinationally, would show up at the wrong cycle.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NUM_SRC     = 11,
  parameter int SWI_BIT     = 8,
  parameter int CMD_SWI_BIT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] event_i,
  output logic        irq_o,
  output logic        err_o
);
  localparam logic [1:0]  A_STAT = 2'd0;
  localparam logic [1:0]  A_MASK = 2'd1;
  localparam logic [1:0]  A_GEN  = 2'd2;
  localparam logic [1:0]  A_CMD  = 2'd3;
  localparam logic [31:0] VALID  = 32'((64'd1 << NUM_SRC) - 64'd1);
  localparam logic [31:0] SWI_M  = 32'd1 << SWI_BIT;

  logic [31:0] stat_q, mask_q, gen_q;
  logic        irq_q, err_q;

  wire        rd_clr   = bus_rd && (bus_addr == A_STAT);
  wire        stat_wr  = bus_wr && (bus_addr == A_STAT);
  wire        swi_post = bus_wr && (bus_addr == A_CMD) && bus_wdata[CMD_SWI_BIT];
  wire [31:0] post_vec = (event_i & VALID) | (swi_post ? SWI_M : 32'd0);
  wire        masked   = |(stat_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      gen_q  <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      stat_q <= (rd_clr ? 32'd0 : stat_q) | post_vec;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata & VALID;
      if (bus_wr && bus_addr == A_GEN)  gen_q  <= bus_wdata;
      irq_q <= masked && (irq_q || (|gen_q));
      err_q <= (|(event_i & ~VALID)) || stat_wr;
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = stat_q;
      A_MASK:  bus_rdata = mask_q;
      A_GEN:   bus_rdata = gen_q;
      default: bus_rdata = 32'd0;
    endcase
  end

  assign irq_o = irq_q;
  assign err_o = err_q;

  // R2
  post_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && (event_i & VALID) != 0) |=> ((stat_q & $past(event_i & VALID)) == $past(event_i & VALID)));
  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && event_i == 0 && !bus_wr) |=> (stat_q == 32'd0));
  // R4
  read_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((stat_q & $past(event_i & VALID)) == $past(event_i & VALID)));
  // R5
  stat_wr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !bus_rd && event_i == 0) |=> ($stable(stat_q) && err_o));
  // R6
  reserved_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_i & ~VALID) != 0) |=> err_o);
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(stat_q & mask_q)) && (gen_q != 0)) |=> irq_o);
  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) == 0) |=> !irq_o);
  // R10
  irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && (|(stat_q & mask_q))) |=> irq_o);
  // R6
  stat_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~VALID) == 0));
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wd = '0, ev = '0;
  logic [31:0] rdata;
  logic        irq, err;

  localparam logic [1:0] STAT = 2'd0, MASK = 2'd1, GEN = 2'd2, CMD = 2'd3;
  localparam int K_IRQ = 0, K_ERR = 1, K_RD = 2;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rdata), .event_i(ev), .irq_o(irq), .err_o(err)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic cyc(input logic w, input logic r, input logic [1:0] a,
                     input logic [31:0] d, input logic [31:0] e);
    @(negedge clk);
    wr = w; rd = r; addr = a; wd = d; ev = e;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, STAT, 32'd0, 32'd0);
  endtask

  task automatic expect_item(input int k, input logic [31:0] v, input string t);
    item_t it;
    it.kind = k; it.exp = v; it.tag = t;
    sb.push_back(it);
  endtask

  // monitor: compares queued expectations 1 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_IRQ:   act = {31'd0, irq};
          K_ERR:   act = {31'd0, err};
          default: act = rdata;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(0, 1, STAT, 0, 0);
    expect_item(K_RD, 32'd0, "R1 status");
    expect_item(K_IRQ, 32'd0, "R1 irq");
    expect_item(K_ERR, 32'd0, "R1 err");
    cyc(0, 0, MASK, 0, 0); expect_item(K_RD, 32'd0, "R1 mask");
    cyc(0, 0, GEN, 0, 0);  expect_item(K_RD, 32'd0, "R1 enable");

    cyc(1, 0, MASK, 32'h7FF, 0);
    cyc(1, 0, GEN, 32'd1, 0);
    idle();

    // R7 rise timing, R3 read-clear, R8 fall
    cyc(0, 0, STAT, 0, 32'h1);
    idle(); expect_item(K_IRQ, 32'd0, "R7 registered lag");
    idle(); expect_item(K_IRQ, 32'd1, "R7 asserted");
    cyc(0, 1, STAT, 0, 0); expect_item(K_RD, 32'h1, "R3 returns value");
    cyc(0, 1, STAT, 0, 0); expect_item(K_RD, 32'h0, "R3 cleared");
    expect_item(K_IRQ, 32'd1, "R8 one cycle lag");
    idle(); expect_item(K_IRQ, 32'd0, "R8 deasserted");

    // R2 OR accumulation
    cyc(0, 0, STAT, 0, 32'h1);
    cyc(0, 0, STAT, 0, 32'h10);
    cyc(0, 1, STAT, 0, 0); expect_item(K_RD, 32'h11, "R2 or");
    idle(); idle();

    // R4 event during read-clear
    cyc(0, 0, STAT, 0, 32'h2);
    cyc(0, 1, STAT, 0, 32'h4); expect_item(K_RD, 32'h2, "R4 read value");
    cyc(0, 1, STAT, 0, 0);     expect_item(K_RD, 32'h4, "R4 event kept");
    idle(); idle();

    // R5 status write rejected
    cyc(0, 0, STAT, 0, 32'h8);
    cyc(1, 0, STAT, 32'hFFFF_FFFF, 0);
    cyc(0, 1, STAT, 0, 0);
    expect_item(K_RD, 32'h8, "R5 unchanged");
    expect_item(K_ERR, 32'd1, "R5 err");
    idle(); expect_item(K_ERR, 32'd0, "R5 err pulse ends");
    idle();

    // R6 reserved event
    cyc(0, 0, STAT, 0, 32'h8000_0001);
    cyc(0, 1, STAT, 0, 0);
    expect_item(K_RD, 32'h1, "R6 reserved dropped");
    expect_item(K_ERR, 32'd1, "R6 err");
    idle(); idle();

    // R11 software command
    cyc(1, 0, CMD, 32'h1, 0);
    cyc(0, 1, STAT, 0, 0); expect_item(K_RD, 32'h100, "R11 swi posted");
    cyc(1, 0, CMD, 32'hFFFF_FFFE, 0);
    cyc(0, 1, STAT, 0, 0); expect_item(K_RD, 32'h0, "R11 no post");
    idle(); idle();

    // R12 all source positions
    cyc(0, 0, STAT, 0, 32'h7FF);
    cyc(0, 1, STAT, 0, 0); expect_item(K_RD, 32'h7FF, "R12 all sources");
    cyc(0, 0, STAT, 0, 32'h400);
    cyc(0, 1, STAT, 0, 0); expect_item(K_RD, 32'h400, "R12 rx reset done bit 10");
    idle(); idle();

    // R9 mask re-evaluation
    cyc(1, 0, MASK, 32'h0, 0);
    cyc(0, 0, STAT, 0, 32'h40);
    idle();
    idle(); expect_item(K_IRQ, 32'd0, "R9 masked");
    cyc(1, 0, MASK, 32'h40, 0);
    idle(); expect_item(K_IRQ, 32'd0, "R9 lag");
    idle(); expect_item(K_IRQ, 32'd1, "R9 unmask raises");
    cyc(1, 0, MASK, 32'h0, 0);
    idle(); expect_item(K_IRQ, 32'd1, "R8 mask lag");
    idle(); expect_item(K_IRQ, 32'd0, "R8 mask lowers");
    cyc(0, 1, STAT, 0, 0);
    cyc(1, 0, MASK, 32'h7FF, 0);
    idle(); idle();

    // R10 global enable gate and pending latch
    cyc(1, 0, GEN, 32'd0, 0);
    cyc(0, 0, STAT, 0, 32'h1);
    idle(); idle();
    idle(); expect_item(K_IRQ, 32'd0, "R10 gated");
    cyc(0, 1, STAT, 0, 0);
    idle();
    cyc(1, 0, GEN, 32'd1, 0);
    cyc(0, 0, STAT, 0, 32'h1);
    idle();
    idle(); expect_item(K_IRQ, 32'd1, "R10 enabled");
    cyc(1, 0, GEN, 32'd0, 0);
    idle(); idle();
    idle(); expect_item(K_IRQ, 32'd1, "R10 latch holds");
    cyc(0, 1, STAT, 0, 0);
    idle();
    idle(); expect_item(K_IRQ, 32'd0, "R10 released");

    idle(); idle();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule